// File: doc/BRIEF.md
# Mark-Space Carrier Modulator

This block produces an infrared-style transmit line from an incoming carrier and a programmable mark/space timer. A mark interval, during which a gate is open, is followed by a space interval, during which the gate is closed. After the space the cycle starts again. The mark is timed by a 17-bit down counter whose top bit acts as a sign bit. Once that counter underflows, the same counter keeps counting down into negative values. The space ends when the bitwise complement of its low 16 bits equals the latched space value, so no second counter is needed.

Three output styles are available:
- The gate ANDs the carrier onto the line (time mode).
- The gate drives the line level by itself (baseband mode).
- The carrier is gated as in time mode, and a select line to an external carrier generator flips after every complete mark-plus-space period (frequency-shift mode).

The counter steps either on every clock or once per carrier period, using a strobe that arrives with the carrier. When the block is disabled, the line follows a software output latch. A polarity bit inverts the line in every state.

Control is a four-state machine:
- `ST_OFF`: block disabled.
- `ST_ARM`: enabled, waiting for the first count tick.
- `ST_MARK`: gate open.
- `ST_SPACE`: gate closed, comparator active.

The machine has these transitions:
- T_ENABLE: `ST_OFF` to `ST_ARM` when enable is high.
- T_LOAD: `ST_ARM` to `ST_MARK` on a tick. This loads the counter and the space register.
- T_UNDERFLOW: `ST_MARK` to `ST_SPACE` on the tick at which the counter is zero.
- T_MATCH: `ST_SPACE` to `ST_MARK` on the tick at which the comparator matches. This reloads both registers and pulses the end-of-cycle output.
- T_DISABLE: any state to `ST_OFF` when enable is low.

Top module: `ir_mark_space_mod`

## Requirements
- R1: On the first count tick after enable is seen high, the counter loads the mark buffer (sign bit zero) and the space register loads the space buffer. The gate is open from the enable until the mark ends. `carrier_sel` is 0 at start.
- R2: The mark phase (gate open) lasts mark_buf+1 count ticks after the load tick. A mark value of 0 gives a one-tick mark.
- R3: The space phase (gate closed) lasts space_buf+1 count ticks. It ends when the complement of the counter's low 16 bits equals the latched space value. A space value of 0 ends it on the first tick after underflow.
- R4: Changes to `mark_buf` or `space_buf` during a period take effect only at the next load or match.
- R5: `cycle_end` is high for exactly one clock, in the clock after each comparator match.
- R6: Time mode (`mode` = 2'b00, and also 2'b11): while enabled, `tx_out` = (carrier_in AND gate) XOR polarity.
- R7: Baseband mode (`mode` = 2'b01): while enabled, `tx_out` = gate XOR polarity, and the carrier has no effect.
- R8: Frequency-shift mode (`mode` = 2'b10): the carrier is gated as in time mode, and `carrier_sel` toggles in the clock of each `cycle_end`. In all other modes `carrier_sel` holds.
- R9: With `count_sel` = 0 the counter ticks on every clock. With `count_sel` = 1 it ticks only on clocks with `carrier_strobe` high.
- R10: With enable low, `tx_out` = out_latch XOR polarity. The state returns to `ST_OFF` and `carrier_sel` clears to 0 on the next clock.
- R11: `polarity` = 1 inverts `tx_out` both when enabled and when disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Modulator enable |
| mode | input | 2 | 00 time, 01 baseband, 10 frequency-shift, 11 as time |
| count_sel | input | 1 | 0: tick every clock; 1: tick on carrier strobe |
| polarity | input | 1 | 1 inverts tx_out |
| out_latch | input | 1 | Line level while disabled |
| mark_buf | input | 16 | Mark period buffer |
| space_buf | input | 16 | Space period buffer |
| carrier_in | input | 1 | Carrier waveform |
| carrier_strobe | input | 1 | One-clock pulse per carrier period |
| tx_out | output | 1 | Transmit line |
| carrier_sel | output | 1 | Carrier frequency select (0 primary) |
| cycle_end | output | 1 | One-clock pulse per completed period |

## Verification
The assertions assume that inputs change only between clock edges and that `carrier_strobe` is a single-clock pulse that comes at most once per carrier period. The stimulus meets this by driving from a bench carrier generator with a period of at least two clocks. They also assume the block is in `ST_OFF` after reset. The stimulus holds enable low through reset. Random segments keep mark and space values small so that many periods complete, and they reprogram the buffers and toggle enable mid-period. Directed cases cover zero values, buffer updates and strobe-driven counting.

// File: rtl/ir_msm_pkg.sv
package ir_msm_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARM   = 2'd1,
        ST_MARK  = 2'd2,
        ST_SPACE = 2'd3
    } msm_state_e;

    typedef enum logic [1:0] {
        MODE_TIME  = 2'b00,
        MODE_BASE  = 2'b01,
        MODE_FSK   = 2'b10,
        MODE_SPARE = 2'b11
    } msm_mode_e;
endpackage

// File: rtl/ir_msm_tick.sv
module ir_msm_tick #(
    parameter bit ALLOW_CARRIER_COUNT = 1'b1
) (
    input  logic count_sel,
    input  logic carrier_strobe,
    output logic tick
);
    generate
        if (ALLOW_CARRIER_COUNT) begin : g_sel
            always_comb tick = count_sel ? carrier_strobe : 1'b1;
        end else begin : g_bus_only
            logic unused_in;
            always_comb unused_in = count_sel ^ carrier_strobe;
            always_comb tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ir_msm_timer.sv
module ir_msm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic             in_mark,
    input  logic             in_space,
    input  logic [CNT_W-1:0] mark_buf,
    input  logic [CNT_W-1:0] space_buf,
    output logic             mark_last,
    output logic             space_hit
);
    localparam int FULL_W = CNT_W + 1;

    logic [FULL_W-1:0] cnt_q;
    logic [CNT_W-1:0]  spc_q;
    logic              sign;

    always_comb sign = cnt_q[FULL_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            spc_q <= '0;
        end else if (load) begin
            cnt_q <= {1'b0, mark_buf};
            spc_q <= space_buf;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        mark_last = (cnt_q == '0);
        space_hit = sign && ((~cnt_q[CNT_W-1:0]) == spc_q);
    end

    // R2: while marking, the sign bit stays clear
    p_mark_sign_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_mark |-> !sign);
    // R3: while spacing, the counter is negative
    p_space_sign_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_space |-> sign);
    // R3: complement never passes the latched space value
    p_space_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_space |-> ((~cnt_q[CNT_W-1:0]) <= spc_q));
    // R1: a load captures the mark buffer with a clear sign bit
    p_load_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == {1'b0, $past(mark_buf)}));
endmodule

// File: rtl/ir_msm_fsm.sv
module ir_msm_fsm
    import ir_msm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode,
    input  logic       tick,
    input  logic       mark_last,
    input  logic       space_hit,
    output logic       load,
    output logic       dec,
    output logic       in_mark,
    output logic       in_space,
    output logic       gate,
    output logic       carrier_sel,
    output logic       cycle_end
);
    msm_state_e state_q, state_d;
    logic       match;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;                              // T_DISABLE
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_ARM;                // T_ENABLE
                ST_ARM:   if (tick) state_d = ST_MARK;     // T_LOAD
                ST_MARK:  if (tick && mark_last) state_d = ST_SPACE;  // T_UNDERFLOW
                ST_SPACE: if (tick && space_hit) state_d = ST_MARK;   // T_MATCH
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        in_mark  = (state_q == ST_MARK);
        in_space = (state_q == ST_SPACE);
        gate     = (state_q == ST_ARM) || (state_q == ST_MARK);
        match    = enable && tick && in_space && space_hit;
        load     = (enable && tick && (state_q == ST_ARM)) || match;
        dec      = enable && tick && (in_mark || (in_space && !space_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cycle_end   <= 1'b0;
            carrier_sel <= 1'b0;
        end else begin
            cycle_end <= match;
            if (!enable)
                carrier_sel <= 1'b0;
            else if (match && (mode == MODE_FSK))
                carrier_sel <= !carrier_sel;
        end
    end

    // R5: end-of-cycle is a single-clock pulse
    p_cycle_end_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !cycle_end);
    // R8: the select line moves only at a period boundary while enabled
    p_sel_only_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (carrier_sel != $past(carrier_sel))) |-> cycle_end);
    // R10: disabling returns the machine to the off state
    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_OFF));
endmodule

// File: rtl/ir_msm_out.sv
module ir_msm_out
    import ir_msm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode,
    input  logic       gate,
    input  logic       carrier_in,
    input  logic       polarity,
    input  logic       out_latch,
    output logic       tx_out
);
    logic modulated;

    always_comb begin
        unique case (mode)
            MODE_BASE: modulated = gate;
            MODE_TIME, MODE_FSK, MODE_SPARE: modulated = gate & carrier_in;
            default:   modulated = gate & carrier_in;
        endcase
        tx_out = (enable ? modulated : out_latch) ^ polarity;
    end

    // R6: a closed gate drives the inactive level while enabled
    p_closed_gate_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !gate) |-> (tx_out == polarity));
endmodule

// File: rtl/ir_mark_space_mod.sv
module ir_mark_space_mod #(
    parameter int CNT_W = 16,
    parameter bit ALLOW_CARRIER_COUNT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             count_sel,
    input  logic             polarity,
    input  logic             out_latch,
    input  logic [CNT_W-1:0] mark_buf,
    input  logic [CNT_W-1:0] space_buf,
    input  logic             carrier_in,
    input  logic             carrier_strobe,
    output logic             tx_out,
    output logic             carrier_sel,
    output logic             cycle_end
);
    logic tick, load, dec, in_mark, in_space, gate, mark_last, space_hit;

    ir_msm_tick #(.ALLOW_CARRIER_COUNT(ALLOW_CARRIER_COUNT)) u_tick (
        .count_sel      (count_sel),
        .carrier_strobe (carrier_strobe),
        .tick           (tick)
    );

    ir_msm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .dec       (dec),
        .in_mark   (in_mark),
        .in_space  (in_space),
        .mark_buf  (mark_buf),
        .space_buf (space_buf),
        .mark_last (mark_last),
        .space_hit (space_hit)
    );

    ir_msm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode        (mode),
        .tick        (tick),
        .mark_last   (mark_last),
        .space_hit   (space_hit),
        .load        (load),
        .dec         (dec),
        .in_mark     (in_mark),
        .in_space    (in_space),
        .gate        (gate),
        .carrier_sel (carrier_sel),
        .cycle_end   (cycle_end)
    );

    ir_msm_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode       (mode),
        .gate       (gate),
        .carrier_in (carrier_in),
        .polarity   (polarity),
        .out_latch  (out_latch),
        .tx_out     (tx_out)
    );
endmodule

// File: tb/ir_mark_space_mod_tb.sv
`timescale 1ns/1ps
module ir_mark_space_mod_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        count_sel = 1'b0;
    logic        polarity = 1'b0;
    logic        out_latch = 1'b0;
    logic [15:0] mark_buf = 16'd0;
    logic [15:0] space_buf = 16'd0;
    logic        carrier_in = 1'b0;
    logic        carrier_strobe = 1'b0;
    logic        tx_out, carrier_sel, cycle_end;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int cper = 3, chigh = 1, cpos = 0;

    always #4 clk = !clk;   // 125 MHz

    ir_mark_space_mod dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .count_sel(count_sel), .polarity(polarity), .out_latch(out_latch),
        .mark_buf(mark_buf), .space_buf(space_buf), .carrier_in(carrier_in),
        .carrier_strobe(carrier_strobe), .tx_out(tx_out),
        .carrier_sel(carrier_sel), .cycle_end(cycle_end)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // bench carrier generator, driven on the falling edge
    always @(negedge clk) begin
        cpos = (cpos + 1 >= cper) ? 0 : cpos + 1;
        carrier_in     <= (cpos < chigh);
        carrier_strobe <= (cpos == 0);
    end

    // reference model: remaining-tick counting per phase
    int  m_st = 0;     // 0 off, 1 arm, 2 mark, 3 space
    int  m_rem = 0, m_spc = 0;
    bit  m_sel = 0, m_ce = 0;

    function automatic bit exp_tx(int st, bit en, logic [1:0] md, bit car, bit lat, bit pol);
        bit g;
        g = (st == 1) || (st == 2);
        if (!en) return lat ^ pol;
        if (md == 2'b01) return g ^ pol;
        return (g & car) ^ pol;
    endfunction

    always @(posedge clk) begin
        bit tk, ce_n;
        string tg;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_ce = 0;
        end else begin
            tk = count_sel ? carrier_strobe : 1'b1;
            ce_n = 0;
            if (!enable) begin
                m_st = 0; m_sel = 0;
            end else begin
                case (m_st)
                    0: m_st = 1;
                    1: if (tk) begin m_st = 2; m_rem = mark_buf + 1; m_spc = space_buf; end
                    2: if (tk) begin m_rem--; if (m_rem == 0) begin m_st = 3; m_rem = m_spc + 1; end end
                    default: if (tk) begin
                        m_rem--;
                        if (m_rem == 0) begin
                            m_st = 2; m_rem = mark_buf + 1; m_spc = space_buf; ce_n = 1;
                            if (mode == 2'b10) m_sel = !m_sel;
                        end
                    end
                endcase
            end
            m_ce = ce_n;
        end
        #2;
        if (rst_n) begin
            if (!enable)          tg = polarity ? "R11" : "R10";
            else if (m_st == 1)   tg = "R1";
            else if (mode == 2'b01) tg = "R7";
            else if (mode == 2'b10) tg = "R8";
            else                  tg = "R6";
            chk(tg, "tx_out", tx_out, exp_tx(m_st, enable, mode, carrier_in, out_latch, polarity));
            chk("R5", "cycle_end", cycle_end, m_ce);
            chk("R8", "carrier_sel", carrier_sel, m_sel);
        end
    end

    task automatic wait_ce();
        int n = 0;
        do begin @(posedge clk); #3; n++; end while (!cycle_end && n < 20000);
    endtask

    task automatic measure(int exp, string tag);
        int n = 0;
        wait_ce();
        do begin @(posedge clk); #3; n++; end while (!cycle_end && n < 20000);
        chk(tag, "period clocks", n, exp);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #3; end
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit s;
        void'($urandom(32'd2024));
        run(4);
        chk("R10", "reset tx_out", tx_out, 0);
        chk("R8", "reset carrier_sel", carrier_sel, 0);
        chk("R5", "reset cycle_end", cycle_end, 0);
        rst_n = 1'b1;
        run(2);
        // R10 / R11: disabled line follows the latch, polarity inverts it
        out_latch = 1'b1; run(1);
        chk("R10", "latch high", tx_out, 1);
        polarity = 1'b1; run(1);
        chk("R11", "latch inverted", tx_out, 0);
        polarity = 1'b0; out_latch = 1'b0;
        // R1: gate opens right after enable
        mode = 2'b01; mark_buf = 16'd3; space_buf = 16'd2; enable = 1'b1;
        run(1);
        chk("R1", "arm gate open", tx_out, 1);
        chk("R1", "sel at start", carrier_sel, 0);
        // R2 / R3: period = (M+1)+(S+1) clocks
        measure(7, "R2");
        mark_buf = 16'd0; space_buf = 16'd0;
        wait_ce();
        measure(2, "R3");
        // R4: buffers written mid-period apply at the next boundary
        mark_buf = 16'd3; space_buf = 16'd2;
        wait_ce(); wait_ce();
        run(1);
        mark_buf = 16'd10; space_buf = 16'd5;
        begin
            int n = 0;
            do begin @(posedge clk); #3; n++; end while (!cycle_end);
            chk("R4", "old values period", n, 6);
        end
        measure(17, "R4");
        // R9: counting on carrier strobe, period 4
        enable = 1'b0; run(2);
        cper = 4; chigh = 2; mode = 2'b00; count_sel = 1'b1;
        mark_buf = 16'd2; space_buf = 16'd1; enable = 1'b1;
        measure(20, "R9");
        // R8: frequency-shift toggles select per period
        mode = 2'b10; count_sel = 1'b0;
        wait_ce(); s = carrier_sel;
        wait_ce(); chk("R8", "sel toggled", carrier_sel, !s);
        mode = 2'b00;
        wait_ce(); s = carrier_sel;
        wait_ce(); chk("R8", "sel held in time mode", carrier_sel, s);
        // R7: baseband ignores carrier
        mode = 2'b01; run(40);
        // R10: disable mid-run clears select
        mode = 2'b10; wait_ce(); run(2);
        enable = 1'b0; out_latch = 1'b1; run(1);
        chk("R10", "sel cleared", carrier_sel, 0);
        chk("R10", "tx follows latch", tx_out, 1);
        // random segments
        for (int seg = 0; seg < 24; seg++) begin
            mode = 2'($urandom % 4);
            count_sel = 1'($urandom % 2);
            polarity = 1'($urandom % 2);
            mark_buf = 16'($urandom % 12);
            space_buf = 16'($urandom % 12);
            cper = 2 + int'($urandom % 4);
            chigh = 1 + int'($urandom % (cper - 1));
            enable = 1'b1;
            for (int i = 0; i < 400; i++) begin
                @(posedge clk); #3;
                out_latch = 1'($urandom % 2);
                if ($urandom % 40 == 0) begin
                    mark_buf = 16'($urandom % 12);
                    space_buf = 16'($urandom % 12);
                end
                if ($urandom % 90 == 0) enable = !enable;
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule